// File: doc/BRIEF.md
# Three-Source Interrupt Controller

This block gathers interrupt requests from three places: an external pin, a timer overflow strobe and a comparator event strobe. It keeps a pending flag for each source. It gates each flag by a per-source enable and by a global enable. When at least one request passes, it shows the core the vector number of the highest-priority request. The core accepts an interrupt by pulsing an acknowledge. The block then clears the flag of that source and pulses a request to clear the global enable, so that no second interrupt can be taken until software enables interrupts again.

The external pin is sensed in one of four ways, chosen by a 2-bit sense control. In the two edge modes, an edge is caught in a flag that stays set until it is acknowledged. In low-level mode, the request is never stored: it is present exactly while the pin reads low. The block also has a wake output for a sleeping core. Wake follows any pending source whose own enable is set, whatever the global enable is. All outputs are registered, and reset is synchronous and active high.

Top module: `irq3_ctrl`

## Requirements
- R1: While reset is active and in the first cycle after it, irq_req, irq_vec, gie_clr and wake are all 0 and no flag is pending.
- R2: irq_req is asserted only when gie is 1 and some source is pending with its own enable set. A flag that is set while its source is disabled stays stored, and it raises a request once the enable is set.
- R3: With sense_mode 2'b11, a 0-to-1 change of pin_sync sets the pin flag. With 2'b10, a 1-to-0 change sets it. An edge in the opposite direction sets nothing.
- R4: With sense_mode 2'b00, the pin requests while pin_sync is 0. The request is not stored: it disappears when the pin returns high, and it appears again after an acknowledge if the pin is still low.
- R5: With sense_mode 2'b01, the pin never requests, whatever it does.
- R6: Priority runs pin, then timer overflow, then comparator. irq_vec is 2'd1, 2'd2 or 2'd3 for the winner, and 2'd0 when irq_req is 0.
- R7: An acknowledge clears only the flag of the source shown on irq_vec. The other flags stay pending.
- R8: One cycle after ack, gie_clr is 1 for exactly one cycle. irq_req is 0 in the cycle after ack and in any cycle where gie_clr is 1.
- R9: wake is 1 whenever a source with its own enable set is pending, even when gie is 0.
- R10: A new event for a source that arrives in the same cycle as the acknowledge of that source leaves its flag set.
- R11: An event strobe or a pin edge makes irq_req visible two clock edges after it is sampled. A low level in mode 2'b00 makes it visible one edge after it is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pin_sync | input | 1 | Already synchronized level of the external pin |
| tmr_ovf_evt | input | 1 | One-cycle timer overflow strobe |
| cmp_evt | input | 1 | One-cycle comparator event strobe |
| gie | input | 1 | Global interrupt enable |
| en_pin | input | 1 | Enable for the pin source |
| en_tmr | input | 1 | Enable for the timer source |
| en_cmp | input | 1 | Enable for the comparator source |
| sense_mode | input | 2 | Pin sense: 00 low level, 01 off, 10 falling, 11 rising |
| ack | input | 1 | Core takes the interrupt shown on irq_vec |
| irq_req | output | 1 | Interrupt request to the core |
| irq_vec | output | 2 | Vector number of the request, 0 when none |
| gie_clr | output | 1 | One-cycle request to clear the global enable |
| wake | output | 1 | Wake request for a sleeping core |

## Verification
Two things can land on one source in the same clock: an acknowledge that clears its flag, and a new strobe that sets it. The bench sets this up by driving tmr_ovf_evt high in the same cycle as ack while the timer is the vector being shown. It then enables interrupts again and expects vector 2 to be requested a second time. A matching acknowledge with no new strobe must leave nothing pending, which shows that the second request comes from the coinciding event and not from a flag that was never cleared.

// File: rtl/irq3_pkg.sv
package irq3_pkg;
  localparam int NSRC  = 3;
  localparam int VEC_W = $clog2(NSRC + 1);

  typedef enum logic [1:0] {
    SNS_LOW  = 2'b00,
    SNS_OFF  = 2'b01,
    SNS_FALL = 2'b10,
    SNS_RISE = 2'b11
  } sense_e;

  // source slot order is the priority order
  localparam int SLOT_PIN = 0;
  localparam int SLOT_TMR = 1;
  localparam int SLOT_CMP = 2;
endpackage

// File: rtl/irq3_pin_sense.sv
module irq3_pin_sense
  import irq3_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       pin,
  input  logic [1:0] sense,
  input  logic       clr,
  output logic       pend
);
  logic prev_q;
  logic primed_q;
  logic edge_q;
  logic hit_rise;
  logic hit_fall;
  logic hit_edge;
  logic lvl_req;

  assign hit_rise = primed_q && !prev_q && pin;
  assign hit_fall = primed_q && prev_q && !pin;

  always_comb begin
    hit_edge = 1'b0;
    lvl_req  = 1'b0;
    case (sense_e'(sense))
      SNS_RISE: hit_edge = hit_rise;
      SNS_FALL: hit_edge = hit_fall;
      SNS_LOW:  lvl_req  = !pin;
      default:  ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q   <= 1'b1;
      primed_q <= 1'b0;
      edge_q   <= 1'b0;
    end else begin
      prev_q   <= pin;
      primed_q <= 1'b1;
      if (hit_edge)
        edge_q <= 1'b1;
      else if (clr)
        edge_q <= 1'b0;
    end
  end

  assign pend = edge_q || lvl_req;
endmodule

// File: rtl/irq3_evt_flag.sv
module irq3_evt_flag (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic flag
);
  // a fresh event outranks a clear in the same cycle
  always_ff @(posedge clk) begin
    if (rst)
      flag <= 1'b0;
    else if (set)
      flag <= 1'b1;
    else if (clr)
      flag <= 1'b0;
  end
endmodule

// File: rtl/irq3_arbiter.sv
module irq3_arbiter
  import irq3_pkg::*;
#(
  parameter int N  = NSRC,
  parameter int VW = VEC_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  pend,
  input  logic [N-1:0]  en,
  input  logic          gie,
  input  logic          ack,
  output logic          irq_req,
  output logic [VW-1:0] irq_vec,
  output logic          gie_clr,
  output logic          wake,
  output logic [N-1:0]  clr
);
  logic [N-1:0]  act;
  logic [VW-1:0] win;
  logic          take;

  assign act  = pend & en;
  assign take = ack && irq_req;

  // lowest slot wins: scan from the top so lower slots overwrite
  always_comb begin
    win = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (act[i])
        win = VW'(i + 1);
    end
  end

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_clr
      assign clr[g] = take && (irq_vec == VW'(g + 1));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_req <= 1'b0;
      irq_vec <= '0;
      gie_clr <= 1'b0;
      wake    <= 1'b0;
    end else begin
      gie_clr <= take;
      wake    <= |act;
      if (gie && !take && !gie_clr && (|act)) begin
        irq_req <= 1'b1;
        irq_vec <= win;
      end else begin
        irq_req <= 1'b0;
        irq_vec <= '0;
      end
    end
  end
endmodule

// File: rtl/irq3_ctrl.sv
module irq3_ctrl
  import irq3_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             pin_sync,
  input  logic             tmr_ovf_evt,
  input  logic             cmp_evt,
  input  logic             gie,
  input  logic             en_pin,
  input  logic             en_tmr,
  input  logic             en_cmp,
  input  logic [1:0]       sense_mode,
  input  logic             ack,
  output logic             irq_req,
  output logic [VEC_W-1:0] irq_vec,
  output logic             gie_clr,
  output logic             wake
);
  logic [NSRC-1:0] pend;
  logic [NSRC-1:0] en;
  logic [NSRC-1:0] clr;
  logic [NSRC-1:0] evt;

  assign en[SLOT_PIN]  = en_pin;
  assign en[SLOT_TMR]  = en_tmr;
  assign en[SLOT_CMP]  = en_cmp;
  assign evt[SLOT_PIN] = 1'b0;
  assign evt[SLOT_TMR] = tmr_ovf_evt;
  assign evt[SLOT_CMP] = cmp_evt;

  irq3_pin_sense u_pin (
    .clk   (clk),
    .rst   (rst),
    .pin   (pin_sync),
    .sense (sense_mode),
    .clr   (clr[SLOT_PIN]),
    .pend  (pend[SLOT_PIN])
  );

  genvar s;
  generate
    for (s = SLOT_PIN + 1; s < NSRC; s++) begin : g_evt
      irq3_evt_flag u_flag (
        .clk  (clk),
        .rst  (rst),
        .set  (evt[s]),
        .clr  (clr[s]),
        .flag (pend[s])
      );
    end
  endgenerate

  irq3_arbiter #(.N(NSRC), .VW(VEC_W)) u_arb (
    .clk     (clk),
    .rst     (rst),
    .pend    (pend),
    .en      (en),
    .gie     (gie),
    .ack     (ack),
    .irq_req (irq_req),
    .irq_vec (irq_vec),
    .gie_clr (gie_clr),
    .wake    (wake),
    .clr     (clr)
  );
endmodule

// File: rtl/irq3_ctrl_chk.sv
module irq3_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       gie,
  input logic       ack,
  input logic       irq_req,
  input logic [1:0] irq_vec,
  input logic       gie_clr,
  input logic       wake
);
  assert_vec_valid_R6: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> (irq_vec != 2'd0));

  assert_vec_idle_R6: assert property (@(posedge clk) disable iff (rst)
    !irq_req |-> (irq_vec == 2'd0));

  assert_gated_by_gie_R2: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> $past(gie));

  assert_clr_follows_ack_R8: assert property (@(posedge clk) disable iff (rst)
    (ack && irq_req) |=> gie_clr);

  assert_req_drops_R8: assert property (@(posedge clk) disable iff (rst)
    ack |=> !irq_req);

  assert_clr_single_R8: assert property (@(posedge clk) disable iff (rst)
    gie_clr |=> !gie_clr);

  assert_no_req_on_clr_R8: assert property (@(posedge clk) disable iff (rst)
    gie_clr |-> !irq_req);

  assert_wake_covers_req_R9: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> wake);

  assert_ack_legal_R7: assert property (@(posedge clk) disable iff (rst)
    ack |-> irq_req);
endmodule

bind irq3_ctrl irq3_ctrl_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .gie     (gie),
  .ack     (ack),
  .irq_req (irq_req),
  .irq_vec (irq_vec),
  .gie_clr (gie_clr),
  .wake    (wake)
);

// File: tb/irq3_ctrl_bench.sv
module irq3_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pin_sync = 1'b1;
  logic       tmr_ovf_evt = 1'b0;
  logic       cmp_evt = 1'b0;
  logic       gie = 1'b0;
  logic       en_pin = 1'b0;
  logic       en_tmr = 1'b0;
  logic       en_cmp = 1'b0;
  logic [1:0] sense_mode = 2'b01;
  logic       ack = 1'b0;
  logic       irq_req;
  logic [1:0] irq_vec;
  logic       gie_clr;
  logic       wake;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  irq3_ctrl u_irq3_ctrl (
    .clk(clk), .rst(rst), .pin_sync(pin_sync), .tmr_ovf_evt(tmr_ovf_evt),
    .cmp_evt(cmp_evt), .gie(gie), .en_pin(en_pin), .en_tmr(en_tmr),
    .en_cmp(en_cmp), .sense_mode(sense_mode), .ack(ack), .irq_req(irq_req),
    .irq_vec(irq_vec), .gie_clr(gie_clr), .wake(wake)
  );

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // core takes the interrupt, drops gie, then software sets it again
  task automatic take_irq(input string tag);
    ack = 1'b1;
    step();
    ack = 1'b0;
    check({tag, " R8 gie_clr after ack"}, gie_clr, 1);
    check({tag, " R8 req low after ack"}, irq_req, 0);
    gie = 1'b0;
    step();
    check({tag, " R8 gie_clr one cycle"}, gie_clr, 0);
    gie = 1'b1;
    step();
  endtask

  task automatic quiet_reset();
    gie = 1'b0; en_pin = 1'b0; en_tmr = 1'b0; en_cmp = 1'b0;
    sense_mode = 2'b01; pin_sync = 1'b1; ack = 1'b0;
    tmr_ovf_evt = 1'b0; cmp_evt = 1'b0;
    rst = 1'b1;
    step(2);
    rst = 1'b0;
    step();
  endtask

  task automatic t_reset();
    rst = 1'b1;
    step(2);
    check("R1 req in reset", irq_req, 0);
    check("R1 vec in reset", irq_vec, 0);
    rst = 1'b0;
    gie = 1'b1; en_pin = 1'b1; en_tmr = 1'b1; en_cmp = 1'b1;
    step();
    check("R1 req after reset", irq_req, 0);
    check("R1 wake after reset", wake, 0);
    check("R1 gie_clr after reset", gie_clr, 0);
    step();
    check("R1 no flag pending", wake, 0);
  endtask

  task automatic t_timer();
    quiet_reset();
    gie = 1'b1; en_tmr = 1'b1;
    tmr_ovf_evt = 1'b1;
    step();
    tmr_ovf_evt = 1'b0;
    check("R11 event not yet visible", irq_req, 0);
    step();
    check("R11 event after two edges", irq_req, 1);
    check("R6 timer vector", irq_vec, 2);
    take_irq("timer");
    check("R7 timer flag cleared", irq_req, 0);
    check("R7 timer wake cleared", wake, 0);
  endtask

  task automatic t_gating();
    quiet_reset();
    en_cmp = 1'b1;
    cmp_evt = 1'b1;
    step();
    cmp_evt = 1'b0;
    step(2);
    check("R2 no req without gie", irq_req, 0);
    check("R9 wake without gie", wake, 1);
    gie = 1'b1;
    step();
    check("R2 req once gie set", irq_req, 1);
    check("R6 comparator vector", irq_vec, 3);
    take_irq("cmp");
    gie = 1'b1; en_tmr = 1'b0;
    tmr_ovf_evt = 1'b1;
    step();
    tmr_ovf_evt = 1'b0;
    step(2);
    check("R2 no req when source disabled", irq_req, 0);
    check("R9 no wake when source disabled", wake, 0);
    en_tmr = 1'b1;
    step();
    check("R2 stored flag raises req", irq_req, 1);
    check("R2 stored flag vector", irq_vec, 2);
    take_irq("tmr");
  endtask

  task automatic t_edges();
    quiet_reset();
    gie = 1'b1; en_pin = 1'b1;
    sense_mode = 2'b11;
    pin_sync = 1'b0;
    step(3);
    check("R3 falling ignored in rise mode", irq_req, 0);
    pin_sync = 1'b1;
    step();
    check("R11 edge not yet visible", irq_req, 0);
    step();
    check("R3 rising edge request", irq_req, 1);
    check("R6 pin vector", irq_vec, 1);
    take_irq("rise");
    check("R7 pin edge flag cleared", irq_req, 0);
    sense_mode = 2'b10;
    step();
    pin_sync = 1'b0;
    step(2);
    check("R3 falling edge request", irq_req, 1);
    take_irq("fall");
    pin_sync = 1'b1;
    step(3);
    check("R3 rising ignored in fall mode", irq_req, 0);
  endtask

  task automatic t_level();
    quiet_reset();
    gie = 1'b1; en_pin = 1'b1;
    sense_mode = 2'b00;
    step();
    pin_sync = 1'b0;
    step();
    check("R11 level after one edge", irq_req, 1);
    check("R4 level vector", irq_vec, 1);
    pin_sync = 1'b1;
    step();
    check("R4 level not stored", irq_req, 0);
    check("R4 wake follows level", wake, 0);
    pin_sync = 1'b0;
    step();
    take_irq("level");
    check("R4 level returns after ack", irq_req, 1);
    pin_sync = 1'b1;
    step(2);
  endtask

  task automatic t_off();
    quiet_reset();
    gie = 1'b1; en_pin = 1'b1;
    sense_mode = 2'b01;
    pin_sync = 1'b0;
    step(3);
    check("R5 low ignored in off mode", irq_req, 0);
    pin_sync = 1'b1;
    step(3);
    check("R5 edges ignored in off mode", irq_req, 0);
    check("R5 no wake in off mode", wake, 0);
  endtask

  task automatic t_priority();
    quiet_reset();
    gie = 1'b1; en_pin = 1'b1; en_tmr = 1'b1; en_cmp = 1'b1;
    sense_mode = 2'b10;
    step();
    pin_sync = 1'b0; tmr_ovf_evt = 1'b1; cmp_evt = 1'b1;
    step();
    tmr_ovf_evt = 1'b0; cmp_evt = 1'b0;
    step();
    check("R6 pin wins", irq_vec, 1);
    take_irq("prio1");
    check("R7 others kept, timer next", irq_vec, 2);
    take_irq("prio2");
    check("R7 comparator last", irq_vec, 3);
    take_irq("prio3");
    check("R7 all cleared", irq_req, 0);
  endtask

  task automatic t_collide();
    quiet_reset();
    gie = 1'b1; en_tmr = 1'b1;
    tmr_ovf_evt = 1'b1;
    step();
    tmr_ovf_evt = 1'b0;
    step();
    check("R10 setup timer pending", irq_vec, 2);
    tmr_ovf_evt = 1'b1;
    ack = 1'b1;
    step();
    tmr_ovf_evt = 1'b0;
    ack = 1'b0;
    check("R8 gie_clr on collide", gie_clr, 1);
    gie = 1'b0;
    step();
    gie = 1'b1;
    step();
    check("R10 new event survives ack", irq_req, 1);
    check("R10 vector after collide", irq_vec, 2);
    take_irq("collide");
    check("R10 plain ack clears", irq_req, 0);
  endtask

  initial begin
    step();
    t_reset();
    t_timer();
    t_gating();
    t_edges();
    t_level();
    t_off();
    t_priority();
    t_collide();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule